// File: doc/BRIEF.md
# SPI Slave with Echo on Empty Transmit

This block is a serial peripheral interface target. It sits behind a small host register interface and talks to an external bus master over a clock, a data-in line, a data-out line and an active-low select. The host sets clock polarity, clock phase and character length. It writes outgoing words and reads received ones. Status flags report that the transmit holding slot is free, that a received character is waiting, and that a character was lost because the host did not read in time.

The serial clock, data-in and select pins pass through two-flop synchronisers, and edges are found in the system clock domain. The system clock must run at least four times faster than the serial clock. There is one shift register for both directions. When the host has supplied no fresh word for the next character, the shift register still holds the character just received, and that character goes back out. A word written while the shift register is not claimed goes into it at once. Later writes wait in a holding slot, each one replacing the previous one. The newest is taken at the start of the next transfer (select falling) or at the end of the current character.

The controller is a three-state machine. OFF is the disabled state. IDLE means enabled with select high. SHIFT means enabled with select low. The transitions are enable (OFF to IDLE), select (IDLE to SHIFT when the synchronised select is low), deselect (SHIFT to IDLE when it goes high) and disable (IDLE or SHIFT to OFF). A disable pulse wins over an enable pulse in the same cycle.

Top module: `spi_echo_slave`

## Requirements
- R1: After reset the block is disabled, `tx_empty` is 1, `rx_full` and `overrun` are 0, `miso_oe` is 0, and the shift register is zero, so a first character sent without any write is all zeros.
- R2: A one-cycle `en_set` pulse enables the block and an `en_clr` pulse disables it, with `en_clr` winning when both are high. While disabled, serial activity changes no flag and no received data.
- R3: `cfg_cpol` gives the idle level of the serial clock. With `cfg_cpha`=0 data is sampled on the leading edge, and with 1 on the trailing edge. The character length is 8 plus `cfg_bits`, and codes above 8 give 16. Bits travel most significant first.
- R4: When the last bit of a character is sampled, `rx_data` takes the character, zero-extended, and `rx_full` goes to 1.
- R5: If a character completes while `rx_full` is already 1 and `rd_rx` is not pulsed in that cycle, `overrun` goes to 1, and `rx_data` still takes the new character.
- R6: A `rd_status` pulse clears `overrun`, unless a new overrun is set in the same cycle.
- R7: A `rd_rx` pulse clears `rx_full`, unless a character completes in the same cycle.
- R8: A host write while the shift register holds no unsent host word, no character is in progress and the holding slot is empty goes straight into the shift register, and `tx_empty` stays 1.
- R9: Any other write goes to the holding slot and replaces what is there, and `tx_empty` goes to 0. When select falls, the held word moves into the shift register and `tx_empty` returns to 1.
- R10: A word held during a character is loaded into the shift register when that character completes. It is sent as the next character, and `tx_empty` returns to 1.
- R11: When no word is held at the end of a character, the shift register keeps the received character, so the next character echoes it.
- R12: If select rises before a character is complete, the partial bits are discarded. No flag changes, and the next character starts from its first bit.
- R13: `miso_oe` is 1 only while the block is enabled and the synchronised select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | Enable pulse |
| en_clr | input | 1 | Disable pulse |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_bits | input | 4 | Character length minus 8; above 8 means 16 |
| wr_tx | input | 1 | Host write strobe for the transmit word |
| wr_data | input | 16 | Transmit word |
| rd_rx | input | 1 | Host read strobe for the received word |
| rd_status | input | 1 | Host status read strobe, clears overrun |
| rx_data | output | 16 | Last received character |
| tx_empty | output | 1 | Holding slot free |
| rx_full | output | 1 | Unread character present |
| overrun | output | 1 | A character arrived before the previous one was read |
| enabled | output | 1 | Block is enabled |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| nss | input | 1 | Active-low select |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso |

## Verification
A bad bit counter or output index appears on the serial output within one character. The master then reads a shifted or truncated word, and `rx_data` holds a wrongly aligned character at the completion point. A fault in the holding-slot bookkeeping appears as a wrong `tx_empty` one cycle after the write or the select edge, and as the wrong word on the next transfer. Missing echo behaviour shows as zeros or stale data on the character after an unwritten one. A wrong flag update shows on `rx_full` or `overrun` in the cycle after a completion or a host read pulse.

// File: rtl/spi_echo_pkg.sv
`timescale 1ns/1ps
package spi_echo_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SHIFT = 2'd2
    } link_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] pins_s
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= pins[g];
                stab_q <= meta_q;
            end
        end
        assign pins_s[g] = stab_q;
    end
endmodule

// File: rtl/spi_clk_edges.sv
`timescale 1ns/1ps
module spi_clk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_e,
    output logic shift_e
);
    logic sck_d;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    always_comb begin
        rise     = sck_s & ~sck_d;
        fall     = ~sck_s & sck_d;
        lead     = cpol ? fall : rise;
        trail    = cpol ? rise : fall;
        sample_e = cpha ? trail : lead;
        shift_e  = cpha ? lead : trail;
    end
endmodule

// File: rtl/spi_echo_slave.sv
`timescale 1ns/1ps
module spi_echo_slave #(
    parameter int W        = 16,
    parameter int MIN_BITS = 8,
    localparam int CW      = $clog2(W - MIN_BITS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic [CW-1:0] cfg_bits,
    input  logic          wr_tx,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_rx,
    input  logic          rd_status,
    output logic [W-1:0]  rx_data,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          overrun,
    output logic          enabled,
    input  logic          sck,
    input  logic          mosi,
    input  logic          nss,
    output logic          miso,
    output logic          miso_oe
);
    import spi_echo_pkg::*;

    localparam int LW = $clog2(W + 1);

    logic [2:0] pins_s;
    logic       sck_s, mosi_s, nss_s;
    logic       sample_e, shift_e;

    spi_pin_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   ({nss, mosi, sck}),
        .pins_s (pins_s)
    );
    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign nss_s  = pins_s[2];

    spi_clk_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .sample_e (sample_e),
        .shift_e  (shift_e)
    );

    // ---------------- state machine ----------------
    link_state_t state, state_nx;
    logic        active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (en_set && !en_clr) state_nx = ST_IDLE;
            ST_IDLE:  if (en_clr)            state_nx = ST_OFF;
                      else if (!nss_s)       state_nx = ST_SHIFT;
            ST_SHIFT: if (en_clr)            state_nx = ST_OFF;
                      else if (nss_s)        state_nx = ST_IDLE;
            default:                         state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        enabled = (state != ST_OFF);
        active  = (state == ST_SHIFT) && !nss_s;
        miso_oe = active;
    end

    // ---------------- character framing ----------------
    logic [LW-1:0] char_len, bit_cnt, out_idx, out_pos;
    logic [W-1:0]  mask, shifted_in, rx_char;
    logic [W-2:0]  rx_acc;
    logic          in_char, last_bit, sample_ev, shift_ev, char_done, xfer_start;

    always_comb begin
        if (cfg_bits > CW'(W - MIN_BITS)) char_len = LW'(W);
        else                               char_len = LW'(MIN_BITS) + LW'(cfg_bits);
        mask       = {W{1'b1}} >> (LW'(W) - char_len);
        shifted_in = {rx_acc, mosi_s};
        rx_char    = shifted_in & mask;
        sample_ev  = active && sample_e;
        shift_ev   = active && shift_e;
        last_bit   = (bit_cnt == char_len - LW'(1));
        char_done  = sample_ev && last_bit;
        xfer_start = (state == ST_IDLE) && (state_nx == ST_SHIFT);
        out_pos    = char_len - LW'(1) - out_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            out_idx <= '0;
            in_char <= 1'b0;
            rx_acc  <= '0;
        end else if (!active) begin
            bit_cnt <= '0;
            out_idx <= '0;
            in_char <= 1'b0;
        end else begin
            if (sample_ev) begin
                rx_acc  <= shifted_in[W-2:0];
                bit_cnt <= last_bit ? '0 : bit_cnt + LW'(1);
                in_char <= !last_bit;
            end
            if (shift_ev) begin
                out_idx <= bit_cnt;
                in_char <= 1'b1;
            end
        end
    end

    // ---------------- transmit path ----------------
    logic [W-1:0] sh_reg, hold_reg;
    logic         hold_valid, sh_fresh, direct_ok;

    always_comb direct_ok = !sh_fresh && !in_char && !hold_valid && !char_done && !xfer_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_reg     <= '0;
            hold_reg   <= '0;
            hold_valid <= 1'b0;
            sh_fresh   <= 1'b0;
        end else begin
            if (char_done) begin
                if (hold_valid) begin
                    sh_reg     <= hold_reg;
                    hold_valid <= 1'b0;
                    sh_fresh   <= 1'b1;
                end else begin
                    sh_reg   <= rx_char;
                    sh_fresh <= 1'b0;
                end
            end else if (xfer_start) begin
                if (hold_valid) begin
                    sh_reg     <= hold_reg;
                    hold_valid <= 1'b0;
                end
                sh_fresh <= 1'b0;
            end
            if (wr_tx) begin
                if (direct_ok) begin
                    sh_reg   <= wr_data;
                    sh_fresh <= 1'b1;
                end else begin
                    hold_reg   <= wr_data;
                    hold_valid <= 1'b1;
                end
            end
        end
    end

    assign tx_empty = !hold_valid;

    always_comb begin
        miso = 1'b0;
        for (int i = 0; i < W; i++)
            if (out_pos == LW'(i)) miso = sh_reg[i];
    end

    // ---------------- receive path ----------------
    logic ovr_set;
    always_comb ovr_set = char_done && rx_full && !rd_rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (char_done) begin
                rx_data <= rx_char;
                rx_full <= 1'b1;
            end else if (rd_rx) begin
                rx_full <= 1'b0;
            end
            if (ovr_set)        overrun <= 1'b1;
            else if (rd_status) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_echo_checker.sv
`timescale 1ns/1ps
module spi_echo_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         done,
    input logic         rd_rx,
    input logic         rd_status,
    input logic         wr_tx,
    input logic         rx_full,
    input logic         overrun,
    input logic         tx_empty,
    input logic         miso_oe,
    input logic         enabled,
    input logic [W-1:0] rx_data
);
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && $past(!enabled)) |-> $stable(rx_data));

    p_full_after_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);

    p_overrun_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));

    p_status_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !done) |=> !overrun);

    p_data_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !done) |=> !rx_full);

    p_empty_falls_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_tx));

    p_drive_only_enabled_r13: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> enabled);
endmodule

bind spi_echo_slave spi_echo_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (char_done),
    .rd_rx     (rd_rx),
    .rd_status (rd_status),
    .wr_tx     (wr_tx),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .tx_empty  (tx_empty),
    .miso_oe   (miso_oe),
    .enabled   (enabled),
    .rx_data   (rx_data)
);

// File: tb/spi_echo_slave_test.sv
`timescale 1ns/1ps
module spi_echo_slave_test;
    localparam int HALF = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set = 0, en_clr = 0, cfg_cpol = 0, cfg_cpha = 0;
    logic [3:0]  cfg_bits = 4'd0;
    logic        wr_tx = 0, rd_rx = 0, rd_status = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rx_data;
    logic        tx_empty, rx_full, overrun, enabled;
    logic        sck = 0, mosi = 0, nss = 1;
    logic        miso, miso_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    spi_echo_slave uut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_bits(cfg_bits),
        .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx), .rd_status(rd_status),
        .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
        .overrun(overrun), .enabled(enabled),
        .sck(sck), .mosi(mosi), .nss(nss), .miso(miso), .miso_oe(miso_oe)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  code;
        logic        wr;
        logic [15:0] tx;
        logic [15:0] mo;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 4'd0,  1'b0, 16'h0000, 16'h00A5},
        '{2'd0, 4'd0,  1'b0, 16'h0000, 16'h003C},
        '{2'd1, 4'd0,  1'b1, 16'h005A, 16'h000F},
        '{2'd2, 4'd4,  1'b1, 16'h0ABC, 16'h0123},
        '{2'd3, 4'd4,  1'b0, 16'h0000, 16'h00FF},
        '{2'd0, 4'd8,  1'b1, 16'hBEEF, 16'h1234},
        '{2'd1, 4'd15, 1'b0, 16'h0000, 16'hCAFE},
        '{2'd3, 4'd0,  1'b0, 16'h0000, 16'h0077}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_wr(input logic [15:0] d);
        @(negedge clk); wr_tx = 1; wr_data = d;
        @(negedge clk); wr_tx = 0;
    endtask

    task automatic pulse_rd_rx();
        @(negedge clk); rd_rx = 1;
        @(negedge clk); rd_rx = 0;
    endtask

    task automatic pulse_status();
        @(negedge clk); rd_status = 1;
        @(negedge clk); rd_status = 0;
    endtask

    task automatic sel(input logic v);
        @(negedge clk); nss = v; #(HALF);
    endtask

    task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] got);
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            if (!cfg_cpha) begin
                mosi = w[i]; #(HALF);
                got = {got[14:0], miso};
                sck = ~cfg_cpol; #(HALF);
                sck = cfg_cpol;
            end else begin
                sck = ~cfg_cpol; mosi = w[i]; #(HALF);
                got = {got[14:0], miso};
                sck = cfg_cpol;
                if (i != 0) #(HALF);
            end
        end
        #(HALF);
    endtask

    function automatic int len_of(input logic [3:0] c);
        return (c > 4'd8) ? 16 : 8 + int'(c);
    endfunction

    function automatic logic [15:0] mask_of(input int n);
        return 16'hFFFF >> (16 - n);
    endfunction

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic [15:0] sr_model;
        logic [15:0] m;
        int n;
        sr_model = '0;
        tick(4);
        rst_n = 1;
        tick(2);
        // R1 reset state
        chk("R1 tx_empty", 32'(tx_empty), 32'd1);
        chk("R1 rx_full", 32'(rx_full), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 enabled", 32'(enabled), 32'd0);
        chk("R1 miso_oe", 32'(miso_oe), 32'd0);

        @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
        tick(2);
        chk("R2 enabled after set", 32'(enabled), 32'd1);

        // table walk: R3 R4 R8 R11
        foreach (VECS[k]) begin
            @(negedge clk);
            cfg_cpol = VECS[k].mode[1];
            cfg_cpha = VECS[k].mode[0];
            cfg_bits = VECS[k].code;
            sck = cfg_cpol;
            tick(4);
            n = len_of(VECS[k].code);
            m = mask_of(n);
            if (VECS[k].wr) begin
                host_wr(VECS[k].tx);
                tick(1);
                chk("R8 tx_empty after direct write", 32'(tx_empty), 32'd1);
                sr_model = VECS[k].tx;
            end
            sel(1'b0);
            chk("R13 oe while selected", 32'(miso_oe), 32'd1);
            xfer(VECS[k].mo, n, got);
            sel(1'b1);
            chk("R3 R11 miso word", 32'(got & m), 32'(sr_model & m));
            chk("R4 rx_data", 32'(rx_data), 32'(VECS[k].mo & m));
            chk("R4 rx_full", 32'(rx_full), 32'd1);
            chk("R13 oe released", 32'(miso_oe), 32'd0);
            pulse_rd_rx();
            tick(1);
            chk("R7 rx_full cleared", 32'(rx_full), 32'd0);
            sr_model = VECS[k].mo & m;
        end

        // directed: mode 0, 8 bits
        @(negedge clk); cfg_cpol = 0; cfg_cpha = 0; cfg_bits = 0; sck = 0;
        tick(4);

        // R9 held writes overwrite, loaded at select fall
        host_wr(16'h0011);
        host_wr(16'h0022);
        tick(1);
        chk("R9 tx_empty low when held", 32'(tx_empty), 32'd0);
        host_wr(16'h0033);
        sel(1'b0);
        chk("R9 tx_empty after select", 32'(tx_empty), 32'd1);
        xfer(16'h0081, 8, got);
        sel(1'b1);
        chk("R9 newest word sent", 32'(got & 16'hFF), 32'h33);
        pulse_rd_rx();

        // R10 write during character, R11 echo, R5 overrun
        sel(1'b0);
        fork
            xfer(16'h00C3, 8, got);
            begin
                #(HALF * 5);
                host_wr(16'h0044);
                tick(2);
                chk("R10 tx_empty low mid-character", 32'(tx_empty), 32'd0);
            end
        join
        chk("R11 echo of previous char", 32'(got & 16'hFF), 32'h81);
        chk("R10 tx_empty after completion", 32'(tx_empty), 32'd1);
        xfer(16'h0018, 8, got);
        sel(1'b1);
        chk("R10 held word sent next", 32'(got & 16'hFF), 32'h44);
        chk("R5 overrun set", 32'(overrun), 32'd1);
        chk("R5 rx_data replaced", 32'(rx_data), 32'h18);
        pulse_status();
        tick(1);
        chk("R6 overrun cleared", 32'(overrun), 32'd0);
        pulse_rd_rx();

        // R12 partial character discarded
        sel(1'b0);
        xfer(16'h0007, 3, got);
        sel(1'b1);
        chk("R12 no flag on partial", 32'(rx_full), 32'd0);
        sel(1'b0);
        xfer(16'h0096, 8, got);
        sel(1'b1);
        chk("R12 clean next char", 32'(rx_data), 32'h96);
        chk("R12 echo unaffected", 32'(got & 16'hFF), 32'h18);
        pulse_rd_rx();

        // R2 disable ignores serial traffic
        @(negedge clk); en_clr = 1; @(negedge clk); en_clr = 0;
        tick(1);
        chk("R2 disabled", 32'(enabled), 32'd0);
        sel(1'b0);
        chk("R13 no drive while off", 32'(miso_oe), 32'd0);
        xfer(16'h005C, 8, got);
        sel(1'b1);
        chk("R2 rx_full untouched", 32'(rx_full), 32'd0);
        chk("R2 rx_data untouched", 32'(rx_data), 32'h96);
        @(negedge clk); en_set = 1; en_clr = 1; @(negedge clk); en_set = 0; en_clr = 0;
        tick(1);
        chk("R2 clear wins", 32'(enabled), 32'd0);
        @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
        tick(1);
        chk("R2 re-enabled", 32'(enabled), 32'd1);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule